// File: doc/BRIEF.md
# ECP FIFO with Programmed-I/O Service Interrupt

This block holds a 16-byte first-in first-out queue between the host register interface and the peripheral side of an extended-capabilities parallel port. It also produces the interrupt that tells software when to service that queue by programmed I/O. The host fills the queue in the forward direction (host to peripheral) and drains it in the reverse direction (peripheral to host). The peripheral side is a plain push/pop port. Each entry carries a data byte and a tag bit. The tag marks entries that entered through the command/address window rather than the data window.

Software selects the direction, clears both the DMA enable and the service-hold bit, and loads a threshold. The block then compares the live occupancy against that threshold every cycle. The comparison depends on direction. In reverse, the interrupt signals that enough bytes are waiting to be read. In forward, it signals that enough space is free to be written. The full and empty flags let the handler move a whole queue in one burst instead of only the threshold amount. A test mode lets the host both write and read the queue through the data window, which allows software to probe depth and thresholds.

Top module: `ecp_pio_fifo`

## Requirements
- R1: While rst_n is low, fifo_count is 0, fifo_empty is 1, fifo_full is 0, irq is 0, and the stored threshold is 0.
- R2: Entries leave in the order they entered. A host write at offset 0x400 stores its byte with tag 0, and a host write at offset 0x000 stores it with tag 1. The popped entry is shown on host_rdata, or on per_rdata and per_rtag.
- R3: A push while 16 bytes are held is dropped, and a pop while the queue is empty is ignored. In both cases fifo_count does not change.
- R4: fifo_empty is 1 exactly when fifo_count is 0. fifo_full is 1 exactly when fifo_count is 16.
- R5: With dir_rev=1, dma_en=0 and svc_intr=0, irq is 1 when fifo_count is at least 16 minus the threshold. Otherwise irq is 0.
- R6: With dir_rev=0, dma_en=0 and svc_intr=0, irq is 1 when fifo_count is at most the threshold. Otherwise irq is 0.
- R7: irq is 0 whenever dma_en or svc_intr was 1 in the previous cycle.
- R8: A threshold write (cfg_wr=1) with cfg_thresh of 16 or more stores 15. Values 0 to 15 are stored unchanged.
- R9: irq is a registered level. It reflects the count, direction, threshold and enables as they stood one clock earlier.
- R10: Outside test mode, host data writes and command writes push only when dir_rev=0, host reads pop only when dir_rev=1, per_push acts only when dir_rev=1, and per_pop acts only when dir_rev=0. In test mode (test_mode=1), host writes and reads at 0x400 both act, writes at 0x000 are ignored, and the peripheral port is ignored.
- R11: Host accesses at any offset other than 0x000 and 0x400 have no effect on the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops on the clock edge) |
| host_addr | input | 11 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte at the head of the queue |
| per_push | input | 1 | Peripheral push strobe |
| per_pop | input | 1 | Peripheral pop strobe |
| per_wtag | input | 1 | Tag bit of the pushed peripheral entry |
| per_wdata | input | 8 | Peripheral push byte |
| per_rdata | output | 8 | Head byte toward the peripheral |
| per_rtag | output | 1 | Head tag toward the peripheral (1 = command) |
| dir_rev | input | 1 | 1 = reverse (peripheral to host), 0 = forward |
| test_mode | input | 1 | Host-only loopback access through 0x400 |
| dma_en | input | 1 | DMA enable; masks the interrupt |
| svc_intr | input | 1 | Service hold; masks the interrupt |
| cfg_wr | input | 1 | Threshold register write strobe |
| cfg_thresh | input | 5 | Threshold value to store |
| irq | output | 1 | Registered service interrupt |
| fifo_full | output | 1 | 16 bytes held |
| fifo_empty | output | 1 | No bytes held |
| fifo_count | output | 5 | Occupancy 0 to 16 |

## Verification
The interrupt is swept across every occupancy from 0 to 16 in each direction. In reverse this uses thresholds of 0, 12 and 15, plus raw values of 16 and 20. The sweep separates a correct "16 minus threshold" boundary from off-by-one errors and from a swapped direction rule, and it shows that out-of-range thresholds fold onto 15. Mixed data and command writes show that order and tag bits survive. Runs past full and past empty show that the count saturates rather than wrapping. Direction, test mode and stray-offset patterns show that each access path acts only where it is allowed. Toggling the enables while the queue holds one byte shows the one-cycle latency and the masking.

// File: rtl/ecp_pio_pkg.sv
package ecp_pio_pkg;

  // Tag bit position inside a stored entry (tag above the data byte)
  localparam int ENTRY_DATA_W = 8;
  localparam int ENTRY_W      = ENTRY_DATA_W + 1;

  // Saturate a raw threshold onto the usable range 0 .. depth-1
  function automatic int clamp_thr(input int raw, input int depth);
    if (raw > depth - 1) return depth - 1;
    return raw;
  endfunction

  // Direction-dependent service condition
  //   reverse : bytes waiting >= depth - thr
  //   forward : bytes waiting <= thr
  function automatic logic pio_irq_hit(input logic rev, input int cnt,
                                       input int thr, input int depth);
    if (rev) return (cnt >= depth - thr);
    return (cnt <= thr);
  endfunction

endpackage

// File: rtl/ecp_fifo_core.sv
module ecp_fifo_core #(
  parameter int DEPTH = 16,
  parameter int EW    = 9,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [EW-1:0] push_entry,
  output logic [EW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + PW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push_req & ~full;
  assign pop_ok  = pop_req & ~empty;
  assign count   = cnt_q;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/ecp_port_arb.sv
module ecp_port_arb #(
  parameter int               ADDR_W   = 11,
  parameter logic [ADDR_W-1:0] DATA_OFS = 11'h400,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 11'h000,
  localparam int              EW       = ecp_pio_pkg::ENTRY_W
) (
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              per_push,
  input  logic              per_pop,
  input  logic              per_wtag,
  input  logic [7:0]        per_wdata,
  input  logic              dir_rev,
  input  logic              test_mode,
  output logic              push_req,
  output logic              pop_req,
  output logic [EW-1:0]     push_entry
);

  logic hit_data, hit_cmd;
  logic host_push_data, host_push_cmd, host_pop;
  logic per_push_en, per_pop_en;

  assign hit_data = (host_addr == DATA_OFS);
  assign hit_cmd  = (host_addr == CMD_OFS);

  assign host_push_data = host_wr & hit_data & (test_mode | ~dir_rev);
  assign host_push_cmd  = host_wr & hit_cmd  & ~test_mode & ~dir_rev;
  assign host_pop       = host_rd & hit_data & (test_mode | dir_rev);
  assign per_push_en    = per_push & dir_rev  & ~test_mode;
  assign per_pop_en     = per_pop  & ~dir_rev & ~test_mode;

  assign push_req = host_push_data | host_push_cmd | per_push_en;
  assign pop_req  = host_pop | per_pop_en;

  always_comb begin
    if (host_push_cmd)       push_entry = {1'b1, host_wdata};
    else if (host_push_data) push_entry = {1'b0, host_wdata};
    else                     push_entry = {per_wtag, per_wdata};
  end

endmodule

// File: rtl/ecp_irq_gen.sv
module ecp_irq_gen #(
  parameter int DEPTH = 16,
  parameter int THR_W = 4,
  parameter int CW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [THR_W:0]   cfg_thresh,
  input  logic             dir_rev,
  input  logic             dma_en,
  input  logic             svc_intr,
  input  logic [CW-1:0]    count,
  output logic [THR_W-1:0] thresh,
  output logic             irq_cond,
  output logic             irq
);
  import ecp_pio_pkg::*;

  logic [THR_W-1:0] thr_q;
  logic             irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) thr_q <= '0;
    else if (cfg_wr) thr_q <= THR_W'(clamp_thr(int'(cfg_thresh), DEPTH));
  end

  assign irq_cond = ~dma_en & ~svc_intr &
                    pio_irq_hit(dir_rev, int'(count), int'(thr_q), DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_cond;
  end

  assign thresh = thr_q;
  assign irq    = irq_q;

endmodule

// File: rtl/ecp_pio_fifo.sv
module ecp_pio_fifo #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 11,
  localparam int THR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int EW    = ecp_pio_pkg::ENTRY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              per_push,
  input  logic              per_pop,
  input  logic              per_wtag,
  input  logic [7:0]        per_wdata,
  output logic [7:0]        per_rdata,
  output logic              per_rtag,
  input  logic              dir_rev,
  input  logic              test_mode,
  input  logic              dma_en,
  input  logic              svc_intr,
  input  logic              cfg_wr,
  input  logic [THR_W:0]    cfg_thresh,
  output logic              irq,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic [CW-1:0]     fifo_count
);

  // Named internal events, brought out for the checker
  logic          push_req, pop_req, push_ok, pop_ok;
  logic [EW-1:0] push_entry, head;
  logic [THR_W-1:0] thresh_q;
  logic          irq_cond;

  ecp_port_arb #(
    .ADDR_W   (ADDR_W),
    .DATA_OFS (ADDR_W'(11'h400)),
    .CMD_OFS  (ADDR_W'(11'h000))
  ) u_arb (
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .per_push   (per_push),
    .per_pop    (per_pop),
    .per_wtag   (per_wtag),
    .per_wdata  (per_wdata),
    .dir_rev    (dir_rev),
    .test_mode  (test_mode),
    .push_req   (push_req),
    .pop_req    (pop_req),
    .push_entry (push_entry)
  );

  ecp_fifo_core #(.DEPTH(DEPTH), .EW(EW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (push_req),
    .pop_req    (pop_req),
    .push_entry (push_entry),
    .head       (head),
    .count      (fifo_count),
    .full       (fifo_full),
    .empty      (fifo_empty),
    .push_ok    (push_ok),
    .pop_ok     (pop_ok)
  );

  ecp_irq_gen #(.DEPTH(DEPTH), .THR_W(THR_W), .CW(CW)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_thresh (cfg_thresh),
    .dir_rev    (dir_rev),
    .dma_en     (dma_en),
    .svc_intr   (svc_intr),
    .count      (fifo_count),
    .thresh     (thresh_q),
    .irq_cond   (irq_cond),
    .irq        (irq)
  );

  assign host_rdata = head[7:0];
  assign per_rdata  = head[7:0];
  assign per_rtag   = head[EW-1];

endmodule

// File: rtl/ecp_pio_fifo_chk.sv
module ecp_pio_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5,
  parameter int THR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CW-1:0]    count,
  input logic             full,
  input logic             empty,
  input logic             irq,
  input logic             irq_cond,
  input logic             dma_en,
  input logic             svc_intr,
  input logic             dir_rev,
  input logic [THR_W-1:0] thresh,
  input logic             push_req,
  input logic             pop_req,
  input logic             push_ok,
  input logic             pop_ok,
  input logic             cfg_wr,
  input logic [THR_W:0]   cfg_thresh
);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R3
  full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop_ok) |=> (int'(count) == DEPTH));

  // R3
  empty_pop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push_ok) |=> (count == '0));

  // R4
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> (int'($past(count)) == DEPTH - 1));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (int'(count) == int'($past(count)) + 1));

  // R7
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en || svc_intr) |=> !irq);

  // R5
  rev_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && !svc_intr && dir_rev && int'(count) >= DEPTH - int'(thresh)) |=> irq);

  // R6
  fwd_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && !svc_intr && !dir_rev && int'(count) <= int'(thresh)) |=> irq);

  // R9
  irq_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_cond) |=> !irq);

  // R8
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && int'(cfg_thresh) >= DEPTH) |=> (int'(thresh) == DEPTH - 1));

endmodule

bind ecp_pio_fifo ecp_pio_fifo_chk #(.DEPTH(DEPTH), .CW(CW), .THR_W(THR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .count      (fifo_count),
  .full       (fifo_full),
  .empty      (fifo_empty),
  .irq        (irq),
  .irq_cond   (irq_cond),
  .dma_en     (dma_en),
  .svc_intr   (svc_intr),
  .dir_rev    (dir_rev),
  .thresh     (thresh_q),
  .push_req   (push_req),
  .pop_req    (pop_req),
  .push_ok    (push_ok),
  .pop_ok     (pop_ok),
  .cfg_wr     (cfg_wr),
  .cfg_thresh (cfg_thresh)
);

// File: tb/ecp_pio_fifo_tb.sv
module ecp_pio_fifo_tb;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 0, host_rd = 0;
  logic [10:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        per_push = 0, per_pop = 0, per_wtag = 0;
  logic [7:0]  per_wdata = '0;
  logic [7:0]  per_rdata;
  logic        per_rtag;
  logic        dir_rev = 0, test_mode = 0, dma_en = 0, svc_intr = 0;
  logic        cfg_wr = 0;
  logic [4:0]  cfg_thresh = '0;
  logic        irq, fifo_full, fifo_empty;
  logic [4:0]  fifo_count;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ecp_pio_fifo u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .per_push(per_push), .per_pop(per_pop), .per_wtag(per_wtag),
    .per_wdata(per_wdata), .per_rdata(per_rdata), .per_rtag(per_rtag),
    .dir_rev(dir_rev), .test_mode(test_mode), .dma_en(dma_en),
    .svc_intr(svc_intr), .cfg_wr(cfg_wr), .cfg_thresh(cfg_thresh),
    .irq(irq), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .fifo_count(fifo_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic h_wr(input logic [10:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic h_rd(input string tag, input int exp);
    host_addr = 11'h400; host_rd = 1'b1;
    #1 chk(tag, int'(host_rdata), exp);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic p_push(input logic t, input logic [7:0] d);
    per_wtag = t; per_wdata = d; per_push = 1'b1;
    @(negedge clk);
    per_push = 1'b0;
  endtask

  task automatic p_pop(input string tag, input int exp_tag, input int exp_data);
    per_pop = 1'b1;
    #1;
    chk(tag, int'(per_rdata), exp_data);
    chk(tag, int'(per_rtag), exp_tag);
    @(negedge clk);
    per_pop = 1'b0;
  endtask

  task automatic set_thr(input int v);
    cfg_thresh = 5'(v); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic chk_irq(input string tag, input int exp);
    @(negedge clk);
    chk(tag, int'(irq), exp);
  endtask

  // R1: values held while reset is low
  task automatic t_reset();
    rst_n = 1'b0; dir_rev = 0; dma_en = 0; svc_intr = 0; test_mode = 0;
    repeat (2) @(negedge clk);
    chk("R1 count", int'(fifo_count), 0);
    chk("R1 empty", int'(fifo_empty), 1);
    chk("R1 full", int'(fifo_full), 0);
    chk("R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    // stored threshold 0, forward, empty: condition count<=0 holds
    chk_irq("R1 threshold zero after reset", 1);
  endtask

  // R2: order and tag bits
  task automatic t_order();
    dir_rev = 0; test_mode = 0; svc_intr = 1;
    do_reset();
    h_wr(11'h400, 8'hA5);
    h_wr(11'h000, 8'h3C);
    h_wr(11'h400, 8'h0F);
    chk("R2 count after three writes", int'(fifo_count), 3);
    p_pop("R2 first entry", 0, 8'hA5);
    p_pop("R2 command entry", 1, 8'h3C);
    p_pop("R2 third entry", 0, 8'h0F);
    chk("R4 empty after drain", int'(fifo_empty), 1);
    svc_intr = 0;
  endtask

  // R5 / R8: reverse sweep, raw threshold and effective value
  task automatic t_rev_sweep(input int raw, input int eff);
    dir_rev = 1; test_mode = 0; dma_en = 0; svc_intr = 0;
    do_reset();
    set_thr(raw);
    for (int i = 0; i <= DEPTH; i++) begin
      chk_irq($sformatf("R5 R8 rev thr=%0d count=%0d", raw, i),
              (i >= DEPTH - eff) ? 1 : 0);
      chk("R4 full flag", int'(fifo_full), (i == DEPTH) ? 1 : 0);
      if (i < DEPTH) p_push(1'b0, 8'(i));
    end
  endtask

  // R6: forward sweep via host writes
  task automatic t_fwd_sweep(input int thr);
    dir_rev = 0; test_mode = 0; dma_en = 0; svc_intr = 0;
    do_reset();
    set_thr(thr);
    for (int i = 0; i <= DEPTH; i++) begin
      chk_irq($sformatf("R6 fwd thr=%0d count=%0d", thr, i),
              (i <= thr) ? 1 : 0);
      chk("R4 empty flag", int'(fifo_empty), (i == 0) ? 1 : 0);
      if (i < DEPTH) h_wr(11'h400, 8'(i + 8'h40));
    end
  endtask

  // R3: saturation at both ends
  task automatic t_limits();
    dir_rev = 1; test_mode = 0; svc_intr = 1;
    do_reset();
    for (int i = 0; i < DEPTH + 1; i++) p_push(1'b0, 8'(i));
    chk("R3 push on full dropped", int'(fifo_count), DEPTH);
    dir_rev = 0;
    h_wr(11'h400, 8'hEE);
    chk("R3 host write on full dropped", int'(fifo_count), DEPTH);
    for (int i = 0; i < DEPTH; i++) p_pop("R3 order kept", 0, i);
    per_pop = 1'b1; @(negedge clk); per_pop = 1'b0;
    chk("R3 pop on empty ignored", int'(fifo_count), 0);
    h_wr(11'h400, 8'h77);
    p_pop("R3 no phantom entry", 0, 8'h77);
    svc_intr = 0;
  endtask

  // R7 / R9: masking and one-cycle latency
  task automatic t_gate();
    dir_rev = 1; test_mode = 0; dma_en = 0; svc_intr = 0;
    do_reset();
    set_thr(15);
    p_push(1'b0, 8'h11);
    chk_irq("R5 one byte, thr 15", 1);
    dma_en = 1'b1;
    #1 chk("R9 irq unchanged before edge", int'(irq), 1);
    chk_irq("R7 dma_en masks", 0);
    dma_en = 1'b0;
    chk_irq("R9 irq returns next cycle", 1);
    svc_intr = 1'b1;
    chk_irq("R7 svc_intr masks", 0);
    svc_intr = 1'b0;
  endtask

  // R10: direction routing
  task automatic t_dir();
    dir_rev = 1; test_mode = 0; svc_intr = 1;
    do_reset();
    h_wr(11'h400, 8'h01);
    h_wr(11'h000, 8'h02);
    chk("R10 host writes ignored in reverse", int'(fifo_count), 0);
    p_push(1'b1, 8'h5A);
    per_pop = 1'b1; @(negedge clk); per_pop = 1'b0;
    chk("R10 peripheral pop ignored in reverse", int'(fifo_count), 1);
    dir_rev = 0;
    host_addr = 11'h400; host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
    p_push(1'b0, 8'h99);
    chk("R10 host read and peripheral push ignored in forward", int'(fifo_count), 1);
    p_pop("R10 reverse entry kept", 1, 8'h5A);
    svc_intr = 0;
  endtask

  // R10: test mode loopback
  task automatic t_test();
    dir_rev = 0; test_mode = 1; svc_intr = 1;
    do_reset();
    h_wr(11'h400, 8'h11);
    h_wr(11'h000, 8'h33);
    h_wr(11'h400, 8'h22);
    p_push(1'b0, 8'h44);
    chk("R10 test mode count", int'(fifo_count), 2);
    h_rd("R10 test readback 1", 8'h11);
    h_rd("R10 test readback 2", 8'h22);
    chk("R10 test drained", int'(fifo_count), 0);
    test_mode = 0; svc_intr = 0;
  endtask

  // R11: stray offsets
  task automatic t_addr();
    dir_rev = 0; test_mode = 0; svc_intr = 1;
    do_reset();
    h_wr(11'h123, 8'hAA);
    h_wr(11'h401, 8'hBB);
    chk("R11 stray write ignored", int'(fifo_count), 0);
    h_wr(11'h400, 8'hCC);
    dir_rev = 1;
    host_addr = 11'h7FF; host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
    chk("R11 stray read ignored", int'(fifo_count), 1);
    svc_intr = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_order();
    t_rev_sweep(12, 12);
    t_rev_sweep(0, 0);
    t_rev_sweep(15, 15);
    t_rev_sweep(16, 15);
    t_rev_sweep(20, 15);
    t_fwd_sweep(12);
    t_fwd_sweep(0);
    t_limits();
    t_gate();
    t_dir();
    t_test();
    t_addr();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule